// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming and acknowledge engine of an eight-line interrupt controller. Software reaches it through a byte-wide bus with two addresses. Writes to address 0 carry either the word that starts initialization or an operation command. Commands cover end-of-interrupt, rotation, read selection, poll and special mask. Writes to address 1 either load the interrupt mask or supply the next word of the initialization sequence. The block holds the mask, the in-service set, the rotating priority base, the vector base and the mode flags. These are passed to an external resolver, which returns the highest pending line.

When the processor runs an interrupt acknowledge, the block returns an 8-bit vector. It also marks the line in service, or, in automatic end-of-interrupt mode, may rotate priority instead. It tells the request capture logic which line was taken. A polled read gives software the same acknowledge through the bus, one read at a time.

Top module: `pic_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, the mask, the in-service set, the priority base, the vector base, the poll flag and every mode flag are zero, and the sequencer waits for normal data. A read of address 0 then returns the request byte.
- R2: A write to address 0 with bit 4 set clears the mask, the in-service set, the base, the vector base, the poll flag, the read select, the special-mask flag, rotate-on-auto-EOI, nested mode and auto-EOI. It latches word-4-needed from bit 0, single mode from bit 1 and level mode from bit 3, and expects the vector-base word next.
- R3: The next address-1 write stores bits 7:3 as the vector base, with bits 2:0 zero. The sequence then goes to the mode word if single and word-4-needed are both set. It returns to normal if only single is set, and otherwise goes to a cascade word. The cascade word changes no register. After it the sequence goes to the mode word if word-4-needed is set, and otherwise back to normal.
- R4: In the mode word, bit 4 sets nested mode and bit 1 sets auto-EOI, and the sequencer returns to normal.
- R5: In the normal state, an address-1 write loads the mask, and an address-1 read returns it.
- R6: An address-0 write with bit 4 clear and bit 3 set requests a poll when bit 2 is set. When bit 1 is set, bit 0 selects an address-0 read of in-service (1) or request (0). When bit 6 is set, the special-mask flag takes bit 5.
- R7: For other address-0 writes, command bits 7:5 = 1 clear the highest-priority in-service bit. The scan starts at the base and rises modulo 8. Command 5 does the same and also sets the base to that line plus 1.
- R8: Command 3 clears the in-service bit named by bits 2:0. Command 7 also sets the base to that line plus 1. Command 6 sets the base to bits 2:0 plus 1 and clears nothing. Command 2 changes nothing.
- R9: Commands 0 and 4 set rotate-on-auto-EOI to bit 7.
- R10: On an acknowledge of a pending line, the line's in-service bit is set when auto-EOI is off. When auto-EOI is on, the in-service set is unchanged, and the base becomes the line plus 1 only if rotate-on-auto-EOI is set.
- R11: During an acknowledge, the vector is the vector base plus the pending line. With no line pending it is the vector base plus 7, and no state changes.
- R12: A read while a poll is requested returns 0x80 plus the line number and performs an acknowledge. If no line is pending it returns 0. Either way the poll request is cleared, so the next read is an ordinary register read.
- R13: Every acknowledge that finds a pending line, whether through the acknowledge strobe or through a poll read, drives the capture-logic strobe high with that line number during that cycle. With no line pending the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, effective at the clock edge |
| bus_rd | input | 1 | Read strobe; a poll read takes effect at the clock edge |
| bus_addr | input | 1 | Register address, 0 or 1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| req_i | input | 8 | Current request register from capture logic |
| pend_valid | input | 1 | Resolver has a line to present |
| pend_line | input | 3 | Line chosen by the resolver |
| iack | input | 1 | Interrupt acknowledge strobe |
| vector | output | 8 | Vector returned during acknowledge |
| ack_valid | output | 1 | Acknowledge taken, to capture logic |
| ack_line | output | 3 | Line acknowledged |
| mask_o | output | 8 | Mask register, to resolver |
| isr_o | output | 8 | In-service set, to resolver |
| prio_base_o | output | 3 | Line holding top priority |
| level_mode_o | output | 1 | Level-triggered capture mode |
| special_mask_o | output | 1 | Special-mask flag |
| nested_mode_o | output | 1 | Special nested mode flag |

## Verification
The hardest case to reach is a non-specific end-of-interrupt under a rotated base. Here the line that must be cleared is not the lowest-numbered in-service bit. To get there, the stimulus rotates the base to 5 with a set-base command and acknowledges lines 7 and 4. It then issues a rotating end-of-interrupt, which must clear line 7 rather than line 4 and wrap the base to 0. A specific rotate command then clears the remaining line. Other stimulus walks every initialization path (single with word 4, cascade without it, and level mode) and checks that the cascade word leaves the mask untouched.

// File: rtl/pic_seq_pkg.sv
// Shared types for the interrupt controller command sequencer.
// Assumes an 8-line controller on a byte-wide bus.
package pic_seq_pkg;
    localparam int LINE_N = 8;
    localparam int LINE_W = $clog2(LINE_N);

    // Initialization sequencer position
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    // Decoded bus write kind
    typedef enum logic [2:0] {
        OP_NONE,
        OP_INIT,
        OP_RDCTL,
        OP_ROTCFG,
        OP_EOI_HI,
        OP_EOI_LINE,
        OP_SET_BASE,
        OP_DATA
    } op_t;
endpackage

// File: rtl/pic_cmd_decode.sv
// Classifies a bus write into one operation kind.
// Assumes bus_wr is a single-cycle strobe; bits 2:0 are consumed elsewhere.
module pic_cmd_decode
    import pic_seq_pkg::*;
(
    input  logic       wr,
    input  logic       addr,
    input  logic [7:3] wd_hi,
    output op_t        op
);
    // Command classification by address and control bits
    always_comb begin
        op = OP_NONE;
        if (wr) begin
            if (addr)            op = OP_DATA;
            else if (wd_hi[4])   op = OP_INIT;
            else if (wd_hi[3])   op = OP_RDCTL;
            else begin
                unique case (wd_hi[7:5])
                    3'd0, 3'd4: op = OP_ROTCFG;
                    3'd1, 3'd5: op = OP_EOI_HI;
                    3'd3, 3'd7: op = OP_EOI_LINE;
                    3'd6:       op = OP_SET_BASE;
                    default:    op = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
// Initialization word sequencer: tracks which data word is expected and
// holds the vector base and mode flags. Assumes op comes from pic_cmd_decode.
module pic_init_seq
    import pic_seq_pkg::*;
#(
    parameter int VW = 8,
    localparam int VB_W = VW - LINE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_t             op,
    input  logic [7:3]      wd_hi,
    input  logic [1:0]      wd_lo,
    output logic [VW-1:0]   vbase,
    output logic            level_mode,
    output logic            nested_mode,
    output logic            auto_eoi,
    output logic            mask_load
);
    seq_t            state;
    logic            need_w4;
    logic            single;
    logic [VB_W-1:0] vb_q;

    assign vbase     = {vb_q, {LINE_W{1'b0}}};
    assign mask_load = (op == OP_DATA) && (state == SEQ_IDLE);

    // Sequencer state and latched initialization fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE; need_w4 <= 1'b0; single <= 1'b0;
            level_mode <= 1'b0; nested_mode <= 1'b0; auto_eoi <= 1'b0;
            vb_q <= '0;
        end else if (op == OP_INIT) begin
            state <= SEQ_BASE; need_w4 <= wd_lo[0]; single <= wd_lo[1];
            level_mode <= wd_hi[3]; nested_mode <= 1'b0; auto_eoi <= 1'b0;
            vb_q <= '0;
        end else if (op == OP_DATA) begin
            unique case (state)
                SEQ_BASE: begin
                    vb_q  <= wd_hi[7:3];
                    state <= single ? (need_w4 ? SEQ_MODE : SEQ_IDLE) : SEQ_CASC;
                end
                SEQ_CASC: state <= need_w4 ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: begin
                    nested_mode <= wd_hi[4];
                    auto_eoi    <= wd_lo[1];
                    state       <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assert_init_enters_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_INIT |=> state == SEQ_BASE);
    assert_casc_word_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DATA && state == SEQ_CASC) |=>
            ($stable(vbase) && $stable(nested_mode) && $stable(auto_eoi)));
    assert_mode_word_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DATA && state == SEQ_MODE) |=> state == SEQ_IDLE);
endmodule

// File: rtl/pic_svc_regs.sv
// Service registers: mask, in-service set, rotating base, poll and read
// controls. Applies end-of-interrupt commands and acknowledges.
// Assumes a write and an acknowledge never share a cycle.
module pic_svc_regs
    import pic_seq_pkg::*;
#(
    parameter int N = LINE_N,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_t           op,
    input  logic [7:0]    wdata,
    input  logic          mask_load,
    input  logic          auto_eoi,
    input  logic          poll_read,
    input  logic          ack_fire,
    input  logic [LW-1:0] ack_ln,
    output logic [N-1:0]  mask,
    output logic [N-1:0]  isr,
    output logic [LW-1:0] base,
    output logic          poll,
    output logic          rd_isr,
    output logic          special_mask
);
    logic          rot_aeoi;
    logic          hi_found;
    logic [LW-1:0] hi_line;
    logic [LW-1:0] cmd_line;

    assign cmd_line = wdata[LW-1:0];

    // Highest-priority in-service line, scanning upward from the base
    always_comb begin
        hi_found = 1'b0;
        hi_line  = '0;
        for (int i = 0; i < N; i++) begin
            if (!hi_found && isr[LW'(base + LW'(i))]) begin
                hi_found = 1'b1;
                hi_line  = LW'(base + LW'(i));
            end
        end
    end

    // Register updates from commands, mask loads and acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n || op == OP_INIT) begin
            mask <= '0; isr <= '0; base <= '0; poll <= 1'b0;
            rd_isr <= 1'b0; special_mask <= 1'b0; rot_aeoi <= 1'b0;
        end else begin
            if (mask_load) mask <= wdata[N-1:0];
            if (poll_read) poll <= 1'b0;
            unique case (op)
                OP_RDCTL: begin
                    if (wdata[2]) poll <= 1'b1;
                    if (wdata[1]) rd_isr <= wdata[0];
                    if (wdata[6]) special_mask <= wdata[5];
                end
                OP_ROTCFG: rot_aeoi <= wdata[7];
                OP_EOI_HI: if (hi_found) begin
                    isr[hi_line] <= 1'b0;
                    if (wdata[7]) base <= hi_line + 1'b1;
                end
                OP_EOI_LINE: begin
                    isr[cmd_line] <= 1'b0;
                    if (wdata[7]) base <= cmd_line + 1'b1;
                end
                OP_SET_BASE: base <= cmd_line + 1'b1;
                default: ;
            endcase
            if (ack_fire) begin
                if (!auto_eoi)     isr[ack_ln] <= 1'b1;
                else if (rot_aeoi) base <= ack_ln + 1'b1;
            end
        end
    end

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_load |=> mask == $past(wdata[N-1:0]));
    assert_ack_sets_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !auto_eoi) |=> isr[$past(ack_ln)]);
    assert_aeoi_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && auto_eoi) |=> $stable(isr));
    assert_poll_oneshot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        poll_read |=> !poll);
endmodule

// File: rtl/pic_cmd_seq.sv
// Top: command sequencer of an 8-line interrupt controller. Decodes bus
// writes, runs initialization, serves acknowledges and polled reads.
// Assumes the resolver output (pend_valid/pend_line) is already computed
// from mask_o, isr_o, prio_base_o and the mode outputs.
module pic_cmd_seq
    import pic_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  req_i,
    input  logic        pend_valid,
    input  logic [2:0]  pend_line,
    input  logic        iack,
    output logic [7:0]  vector,
    output logic        ack_valid,
    output logic [2:0]  ack_line,
    output logic [7:0]  mask_o,
    output logic [7:0]  isr_o,
    output logic [2:0]  prio_base_o,
    output logic        level_mode_o,
    output logic        special_mask_o,
    output logic        nested_mode_o
);
    op_t        op;
    logic [7:0] vbase;
    logic       auto_eoi;
    logic       mask_load;
    logic       poll;
    logic       rd_isr;
    logic       poll_read;

    assign poll_read = bus_rd && poll;
    assign ack_valid = (iack || poll_read) && pend_valid;
    assign ack_line  = pend_line;
    assign vector    = vbase | (pend_valid ? {5'd0, pend_line} : 8'd7);

    pic_cmd_decode u_dec (
        .wr(bus_wr), .addr(bus_addr), .wd_hi(bus_wdata[7:3]), .op(op)
    );

    pic_init_seq #(.VW(8)) u_init (
        .clk(clk), .rst_n(rst_n), .op(op),
        .wd_hi(bus_wdata[7:3]), .wd_lo(bus_wdata[1:0]),
        .vbase(vbase), .level_mode(level_mode_o), .nested_mode(nested_mode_o),
        .auto_eoi(auto_eoi), .mask_load(mask_load)
    );

    pic_svc_regs #(.N(LINE_N)) u_svc (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata),
        .mask_load(mask_load), .auto_eoi(auto_eoi), .poll_read(poll_read),
        .ack_fire(ack_valid), .ack_ln(pend_line),
        .mask(mask_o), .isr(isr_o), .base(prio_base_o),
        .poll(poll), .rd_isr(rd_isr), .special_mask(special_mask_o)
    );

    // Read data: poll result, else the selected register
    always_comb begin
        if (poll)          bus_rdata = pend_valid ? {5'b10000, pend_line} : 8'h00;
        else if (bus_addr) bus_rdata = mask_o;
        else               bus_rdata = rd_isr ? isr_o : req_i;
    end

    assert_spurious_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !pend_valid) |=> $stable(isr_o) && $stable(prio_base_o));
endmodule

// File: tb/test_pic_cmd_seq.sv
module test_pic_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] req_i = 8'h5A;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_line = 3'd0;
    logic       iack = 1'b0;
    logic [7:0] vector;
    logic       ack_valid;
    logic [2:0] ack_line;
    logic [7:0] mask_o, isr_o;
    logic [2:0] prio_base_o;
    logic       level_mode_o, special_mask_o, nested_mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pic_cmd_seq i_pic_cmd_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_i(req_i), .pend_valid(pend_valid), .pend_line(pend_line),
        .iack(iack), .vector(vector), .ack_valid(ack_valid), .ack_line(ack_line),
        .mask_o(mask_o), .isr_o(isr_o), .prio_base_o(prio_base_o),
        .level_mode_o(level_mode_o), .special_mask_o(special_mask_o),
        .nested_mode_o(nested_mode_o)
    );

    // Monitor: samples strobed reads and acknowledges mid-cycle, pops expectations
    always @(negedge clk) begin
        if (rst_n && (bus_rd || iack)) begin
            logic [11:0] got;
            got = {ack_valid, ack_valid ? ack_line : 3'd0, iack ? vector : bus_rdata};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected result %h, expected none", got);
            end else begin
                logic [11:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, got, e);
                end
            end
        end
    end

    task automatic chk(input string t, input logic [7:0] got, input logic [7:0] e);
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, got, e);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic pv, input logic [2:0] pl,
                      input logic [7:0] e, input logic ea, input string t);
        exp_q.push_back({ea, ea ? pl : 3'd0, e});
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a; pend_valid = pv; pend_line = pl;
        @(posedge clk); #1;
        bus_rd = 1'b0; pend_valid = 1'b0;
    endtask

    task automatic ack(input logic pv, input logic [2:0] pl,
                       input logic [7:0] e, input string t);
        exp_q.push_back({pv, pv ? pl : 3'd0, e});
        tag_q.push_back(t);
        iack = 1'b1; pend_valid = pv; pend_line = pl;
        @(posedge clk); #1;
        iack = 1'b0; pend_valid = 1'b0;
    endtask

    initial begin
        #(20000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 isr", isr_o, 8'h00);
        chk("R1 base", {5'd0, prio_base_o}, 8'h00);
        rd(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, "R1 mask read");
        rd(1'b0, 1'b0, 3'd0, 8'h5A, 1'b0, "R1 request read");

        // Phase 1: single, word 4, auto-EOI
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h45);                       // R3 vector base 0x40
        wr(1'b1, 8'h02);                       // R4 auto-EOI on
        wr(1'b1, 8'hF0);                       // R5 mask
        chk("R5 mask load", mask_o, 8'hF0);
        rd(1'b1, 1'b0, 3'd0, 8'hF0, 1'b0, "R5 mask read");
        ack(1'b1, 3'd3, 8'h43, "R11 vector line3");
        chk("R10 aeoi isr kept", isr_o, 8'h00);
        chk("R10 aeoi no rotate", {5'd0, prio_base_o}, 8'h00);
        wr(1'b0, 8'h80);                       // R9 rotate-on-aeoi on
        ack(1'b1, 3'd5, 8'h45, "R11 vector line5");
        chk("R9 R10 rotate base", {5'd0, prio_base_o}, 8'h06);
        wr(1'b0, 8'h00);                       // R9 rotate off
        ack(1'b1, 3'd1, 8'h41, "R11 vector line1");
        chk("R9 rotate off", {5'd0, prio_base_o}, 8'h06);

        // Phase 2: cascade word then word 4 with nested mode
        wr(1'b0, 8'h11);
        chk("R2 mask cleared", mask_o, 8'h00);
        chk("R2 base cleared", {5'd0, prio_base_o}, 8'h00);
        wr(1'b1, 8'h2D);                       // vector base 0x28
        wr(1'b1, 8'hFF);                       // cascade word ignored
        chk("R3 cascade ignored", mask_o, 8'h00);
        wr(1'b1, 8'h10);                       // nested on, auto-EOI off
        chk("R4 nested", {7'd0, nested_mode_o}, 8'h01);
        wr(1'b1, 8'h0F);
        chk("R3 back to normal", mask_o, 8'h0F);
        ack(1'b1, 3'd4, 8'h2C, "R3 low bits zero");
        chk("R4 aeoi off sets isr", isr_o, 8'h10);

        // Phase 3: level mode, no word 4, not single
        wr(1'b0, 8'h18);
        chk("R2 isr cleared", isr_o, 8'h00);
        chk("R2 nested cleared", {7'd0, nested_mode_o}, 8'h00);
        chk("R2 level latched", {7'd0, level_mode_o}, 8'h01);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h33);
        chk("R3 R5 mask after casc", mask_o, 8'h33);
        ack(1'b1, 3'd1, 8'h09, "R11 vector level");
        chk("R10 isr set", isr_o, 8'h02);

        // Phase 4: EOI and rotation commands
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        chk("R2 level cleared", {7'd0, level_mode_o}, 8'h00);
        wr(1'b1, 8'h00);
        ack(1'b1, 3'd2, 8'h22, "R11 vector line2");
        ack(1'b1, 3'd6, 8'h26, "R11 vector line6");
        ack(1'b1, 3'd0, 8'h20, "R11 vector line0");
        chk("R10 isr set three", isr_o, 8'h45);
        ack(1'b0, 3'd3, 8'h27, "R11 R13 spurious");
        chk("R11 spurious no change", isr_o, 8'h45);
        wr(1'b0, 8'h0B);
        rd(1'b0, 1'b0, 3'd0, 8'h45, 1'b0, "R6 isr select");
        wr(1'b0, 8'h68);
        chk("R6 special mask on", {7'd0, special_mask_o}, 8'h01);
        rd(1'b0, 1'b0, 3'd0, 8'h45, 1'b0, "R6 select kept");
        wr(1'b0, 8'h48);
        chk("R6 special mask off", {7'd0, special_mask_o}, 8'h00);
        wr(1'b0, 8'h20);
        chk("R7 nonspecific eoi", isr_o, 8'h44);
        wr(1'b0, 8'hA0);
        chk("R7 rotating eoi isr", isr_o, 8'h40);
        chk("R7 rotating eoi base", {5'd0, prio_base_o}, 8'h03);
        wr(1'b0, 8'h40);
        chk("R8 cmd2 isr", isr_o, 8'h40);
        chk("R8 cmd2 base", {5'd0, prio_base_o}, 8'h03);
        wr(1'b0, 8'hC4);
        chk("R8 set base", {5'd0, prio_base_o}, 8'h05);
        chk("R8 set base no clear", isr_o, 8'h40);
        wr(1'b0, 8'h66);
        chk("R8 specific eoi", isr_o, 8'h00);
        ack(1'b1, 3'd7, 8'h27, "R11 vector line7");
        ack(1'b1, 3'd4, 8'h24, "R11 vector line4");
        wr(1'b0, 8'hA0);
        chk("R7 rotated scan isr", isr_o, 8'h10);
        chk("R7 rotated scan base", {5'd0, prio_base_o}, 8'h00);
        wr(1'b0, 8'hE4);
        chk("R8 specific rotate isr", isr_o, 8'h00);
        chk("R8 specific rotate base", {5'd0, prio_base_o}, 8'h05);

        // Polled reads
        wr(1'b0, 8'h0A);
        rd(1'b0, 1'b0, 3'd0, 8'h5A, 1'b0, "R6 request select");
        wr(1'b0, 8'h0C);
        rd(1'b0, 1'b1, 3'd5, 8'h85, 1'b1, "R12 R13 poll hit");
        chk("R12 poll acknowledges", isr_o, 8'h20);
        rd(1'b0, 1'b1, 3'd5, 8'h5A, 1'b0, "R12 poll one shot");
        wr(1'b1, 8'h81);
        wr(1'b0, 8'h0C);
        rd(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, "R12 poll empty");
        rd(1'b1, 1'b0, 3'd0, 8'h81, 1'b0, "R12 poll cleared");

        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule